// File: doc/BRIEF.md
# SD Card Interface Power Sequencer

This block sets the electrical state of the pins between an SD/MMC host and the card. Software writes a small control word that holds a two-bit power field and a direction-polarity bit. The sequencer turns the power field into one of three pin states: clamped low, idle high, or clocked.

The clocked state uses a kernel-clock tick from the host's clock divider. While clocked, the block toggles the card clock once per tick. It counts card-clock rising edges and raises a ready status after the fixed initialisation run, and the command path may start only after that.

The block also drives two direction outputs for external level-shifting transceivers. Each one shows whether the host is driving its group of lines. The polarity bit can invert both. After a module reset, every pin is released to high impedance until software selects a state.

Top module: `sdpwr_top`

## Requirements
- R1: After reset, all output enables (clock, command, eight data lines) are 0, all output levels are 0, both direction outputs are 0 and `initDone` is 0.
- R2: Writing power field `regWdata[1:0]` = 2'b10 (power-cycle) drives clock, command and all data lines with every output enable 1 and every level 0, in the cycle after the write.
- R3: Writing power field 2'b00 (off) or the reserved code 2'b01 enables every output and drives every level 1, with the card clock held high.
- R4: Writing 2'b11 (power-on) enables every output with command and data high. The card clock starts low on entry and toggles once for each cycle in which `ckTick` is 1.
- R5: In power-on, `initDone` stays 0 until the 74th card-clock rising edge (low-to-high toggle) and is 1 from the cycle after it. Ticks outside power-on move neither the clock nor the count.
- R6: Writing 2'b11 again while already in power-on restarts neither the clock nor the rising-edge count.
- R7: Leaving power-on clears `initDone` at once. A later power-on counts again from zero.
- R8: Bit 2 of the write word is the direction polarity. Each direction output equals its group's output enable XOR the polarity bit.
- R9: The power field and polarity change only in the cycle after a write with `regWe` = 1. When `regWe` = 0, `regWdata` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low module reset |
| regWe | input | 1 | Write strobe for the control word |
| regWdata | input | 3 | [1:0] power field, [2] direction polarity |
| ckTick | input | 1 | Kernel-clock tick from the divider, one card-clock half period |
| clkOe | output | 1 | Card clock output enable |
| clkOut | output | 1 | Card clock level |
| cmdOe | output | 1 | Command line output enable |
| cmdOut | output | 1 | Command line idle level |
| datOe | output | 8 | Data line output enables |
| datOut | output | 8 | Data line idle levels |
| dirCmd | output | 1 | Transceiver direction for command and clock |
| dirDat | output | 1 | Transceiver direction for data lines |
| initDone | output | 1 | Initialisation clocks complete; command path may start |

## Verification
A control write and a kernel tick can arrive in the same cycle. The case that matters is a write that leaves power-on, or writes power-on again, in the same cycle as a tick that would add a rising edge. The bench keeps the tick high across writes at each count position. It then checks three things against an arithmetic model: the clock level, that the count restarts only on a real entry to power-on, and the exact cycle of the 74th edge. Every pair of source and destination states is swept with both polarities.

// File: rtl/sdpwr_pkg.sv
package sdpwr_pkg;

  // Power field codes (bits [1:0] of the control word)
  localparam logic [1:0] PWR_OFF   = 2'b00;
  localparam logic [1:0] PWR_RSVD  = 2'b01;
  localparam logic [1:0] PWR_CYCLE = 2'b10;
  localparam logic [1:0] PWR_ON    = 2'b11;

  localparam int WORD_W   = 3;
  localparam int POL_BIT  = 2;

  typedef enum logic [1:0] {
    ST_HIZ   = 2'd0,
    ST_CYCLE = 2'd1,
    ST_OFF   = 2'd2,
    ST_ON    = 2'd3
  } pwrState_e;

  // Strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic driveEn;    // pins driven by the host
    logic driveHigh;  // idle level is high
    logic clkRun;     // card clock toggles on ticks
    logic dirPol;     // invert transceiver direction outputs
  } pwrStrobe_t;

endpackage

// File: rtl/sdpwr_ctrl.sv
module sdpwr_ctrl
  import sdpwr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [WORD_W-1:0] regWdata,
  output pwrStrobe_t        stb
);

  pwrState_e stateQ;
  pwrState_e stateNext;
  logic      polQ;

  function automatic pwrState_e decodeField(input logic [1:0] field);
    pwrState_e res;
    case (field)
      PWR_CYCLE: res = ST_CYCLE;
      PWR_ON:    res = ST_ON;
      default:   res = ST_OFF;  // off and the reserved code
    endcase
    return res;
  endfunction

  always_comb begin
    stateNext = stateQ;
    if (regWe) stateNext = decodeField(regWdata[1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_HIZ;
      polQ   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (regWe) polQ <= regWdata[POL_BIT];
    end
  end

  always_comb begin
    stb.driveEn   = (stateQ != ST_HIZ);
    stb.driveHigh = (stateQ == ST_OFF) || (stateQ == ST_ON);
    stb.clkRun    = (stateQ == ST_ON);
    stb.dirPol    = polQ;
  end

  // R9: state holds without a write
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWe) |-> (stateQ == $past(stateQ)));

  // R4: a power-on write lands in the clocked state
  assert_on_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWe) && ($past(regWdata[1:0]) == PWR_ON)) |-> (stateQ == ST_ON));

  // R3: reserved code behaves as off
  assert_reserved_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWe) && ($past(regWdata[1:0]) == PWR_RSVD)) |-> (stateQ == ST_OFF));

endmodule

// File: rtl/sdpwr_datapath.sv
module sdpwr_datapath
  import sdpwr_pkg::*;
#(
  parameter int DATA_LINES = 8,
  parameter int INIT_CLKS  = 74
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ckTick,
  input  pwrStrobe_t            stb,
  output logic                  clkOe,
  output logic                  clkOut,
  output logic                  cmdOe,
  output logic                  cmdOut,
  output logic [DATA_LINES-1:0] datOe,
  output logic [DATA_LINES-1:0] datOut,
  output logic                  dirCmd,
  output logic                  dirDat,
  output logic                  initDone
);

  localparam int CNT_W = $clog2(INIT_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INIT_CLKS);

  logic             clkQ;
  logic [CNT_W-1:0] riseCnt;
  logic             cntFull;
  logic             idleLvl;
  logic             riseNow;

  assign cntFull = (riseCnt == CNT_MAX);
  assign riseNow = stb.clkRun && ckTick && !clkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkQ <= 1'b0;
    end else if (!stb.clkRun) begin
      clkQ <= 1'b0;
    end else if (ckTick) begin
      clkQ <= ~clkQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt <= '0;
    end else if (!stb.clkRun) begin
      riseCnt <= '0;
    end else if (riseNow && !cntFull) begin
      riseCnt <= riseCnt + 1'b1;
    end
  end

  assign idleLvl  = stb.driveEn & stb.driveHigh;
  assign initDone = stb.clkRun & cntFull;

  assign clkOe  = stb.driveEn;
  assign clkOut = stb.clkRun ? clkQ : idleLvl;
  assign cmdOe  = stb.driveEn;
  assign cmdOut = idleLvl;

  for (genvar g = 0; g < DATA_LINES; g++) begin : g_dat
    assign datOe[g]  = stb.driveEn;
    assign datOut[g] = idleLvl;
  end

  assign dirCmd = cmdOe ^ stb.dirPol;
  assign dirDat = datOe[0] ^ stb.dirPol;

  // R4: clock moves only on a tick while running
  assert_clk_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clkRun && $past(stb.clkRun) && !$past(ckTick)) |-> $stable(clkQ));

  // R4: clock starts low on entry
  assert_clk_low_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.clkRun) |-> !clkQ);

  // R5: count never passes the limit
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt <= CNT_MAX);

  // R6: once done, stays done while running
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(initDone) && stb.clkRun && $past(stb.clkRun)) |-> initDone);

  // R7: leaving power-on clears the status
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.clkRun) |-> !initDone);

endmodule

// File: rtl/sdpwr_top.sv
module sdpwr_top
  import sdpwr_pkg::*;
#(
  parameter int DATA_LINES = 8,
  parameter int INIT_CLKS  = 74
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [WORD_W-1:0]     regWdata,
  input  logic                  ckTick,
  output logic                  clkOe,
  output logic                  clkOut,
  output logic                  cmdOe,
  output logic                  cmdOut,
  output logic [DATA_LINES-1:0] datOe,
  output logic [DATA_LINES-1:0] datOut,
  output logic                  dirCmd,
  output logic                  dirDat,
  output logic                  initDone
);

  pwrStrobe_t stb;

  sdpwr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regWdata (regWdata),
    .stb      (stb)
  );

  sdpwr_datapath #(
    .DATA_LINES (DATA_LINES),
    .INIT_CLKS  (INIT_CLKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ckTick   (ckTick),
    .stb      (stb),
    .clkOe    (clkOe),
    .clkOut   (clkOut),
    .cmdOe    (cmdOe),
    .cmdOut   (cmdOut),
    .datOe    (datOe),
    .datOut   (datOut),
    .dirCmd   (dirCmd),
    .dirDat   (dirDat),
    .initDone (initDone)
  );

  // R2: a driven-low command line means every line is clamped low
  assert_cycle_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOe && !cmdOut) |-> (!clkOut && (datOut == '0) && !initDone));

  // R1: released pins carry no drive on any line
  assert_hiz_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cmdOe |-> (!clkOe && (datOe == '0) && !initDone));

endmodule

// File: tb/sdpwr_top_tb.sv
module sdpwr_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NLINES     = 8;
  localparam int NINIT      = 74;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic [2:0]        regWdata = '0;
  logic              ckTick = 1'b0;
  logic              clkOe, clkOut, cmdOe, cmdOut, dirCmd, dirDat, initDone;
  logic [NLINES-1:0] datOe, datOut;

  int nTests = 0;
  int nFail  = 0;

  // bench model: 0 hiz, 1 cycle, 2 off, 3 on
  int mState = 0;
  int mPol   = 0;
  int mTicks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdpwr_top #(.DATA_LINES(NLINES), .INIT_CLKS(NINIT)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .ckTick(ckTick),
    .clkOe(clkOe), .clkOut(clkOut), .cmdOe(cmdOe), .cmdOut(cmdOut),
    .datOe(datOe), .datOut(datOut), .dirCmd(dirCmd), .dirDat(dirDat),
    .initDone(initDone)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    int drv, hi, on, expClk, expDone, rises;
    on   = (mState == 3);
    drv  = (mState != 0);
    hi   = drv && (mState >= 2);
    rises = (mTicks + 1) / 2;
    expClk  = on ? (mTicks % 2) : hi;
    expDone = on && (rises >= NINIT);
    chk(req, "clkOe", clkOe, drv);
    chk(req, "clkOut", clkOut, expClk);
    chk(req, "cmdOe", cmdOe, drv);
    chk(req, "cmdOut", cmdOut, hi);
    chk(req, "datOe", datOe, drv ? 255 : 0);
    chk(req, "datOut", datOut, hi ? 255 : 0);
    chk(req, "initDone", initDone, expDone);
    chk("R8", "dirCmd", dirCmd, drv ^ mPol);
    chk("R8", "dirDat", dirDat, drv ^ mPol);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWe = 1'b0; ckTick = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mState = 0; mPol = 0; mTicks = 0;
  endtask

  // write with an optional concurrent tick in the same cycle
  task automatic doWrite(input int code, input int pol, input bit withTick);
    int nxt;
    @(negedge clk);
    regWe = 1'b1;
    regWdata = {pol[0], code[1:0]};
    ckTick = withTick;
    @(negedge clk);
    regWe = 1'b0;
    ckTick = 1'b0;
    nxt = (code == 2) ? 1 : (code == 3) ? 3 : 2;
    // a tick in the write cycle counts only if already in power-on
    if (mState == 3 && nxt == 3) mTicks += withTick;
    else mTicks = 0;
    mState = nxt;
    mPol = pol;
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ckTick = 1'b1;
    end
    @(negedge clk);
    ckTick = 1'b0;
    if (mState == 3) mTicks += n;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    doReset();
    checkAll("R1");

    // sweep every source state, every target code, both polarities
    for (int from = 0; from < 3; from++) begin
      for (int to = 0; to < 4; to++) begin
        for (int pol = 0; pol < 2; pol++) begin
          int fromCode;
          string tag;
          fromCode = (from == 0) ? 2 : (from == 1) ? 0 : 3;
          doReset();
          doWrite(fromCode, 0, 1'b0);
          doTicks(5);
          doWrite(to, pol, 1'b1);
          if (to == 2) tag = "R2";
          else if (to < 2) tag = "R3";
          else if (fromCode == 3) tag = "R6";
          else tag = "R4";
          checkAll(tag);
          doTicks(3);
          checkAll(tag);
        end
      end
    end

    // ticks outside power-on have no effect (R5)
    doReset();
    doWrite(2, 0, 1'b0);
    doTicks(9);
    checkAll("R5");
    doWrite(0, 1, 1'b0);
    doTicks(200);
    checkAll("R5");

    // full initialisation run, edge-exact
    doWrite(3, 1, 1'b0);
    checkAll("R4");
    for (int t = 0; t < 2 * NINIT - 1; t++) begin
      doTicks(1);
      if (t % 16 == 0 || t >= 2 * NINIT - 4) checkAll("R5");
    end
    doTicks(1);
    checkAll("R5");
    chk("R5", "initDone after 74th rise", initDone, 1);
    doTicks(11);
    checkAll("R5");

    // rewrite power-on with a tick: no restart (R6)
    doWrite(3, 1, 1'b1);
    checkAll("R6");
    chk("R6", "initDone kept", initDone, 1);

    // leave and re-enter (R7)
    doWrite(0, 0, 1'b1);
    checkAll("R7");
    doWrite(3, 0, 1'b1);
    checkAll("R7");
    doTicks(2 * NINIT - 2);
    checkAll("R7");
    chk("R7", "initDone before 74th rise", initDone, 0);
    doTicks(1);
    checkAll("R7");

    // regWdata without regWe is ignored (R9)
    @(negedge clk);
    regWe = 1'b0;
    regWdata = 3'b110;
    repeat (3) @(negedge clk);
    checkAll("R9");
    regWdata = 3'b000;

    // reset while running (R1)
    doReset();
    checkAll("R1");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule